// File: doc/BRIEF.md
# Two-Stage Calibration Scaler

This block corrects a raw 24-bit converter code with two pairs of coefficients and returns the scaled code. The first pair is global: a zero offset and a gain. The second pair belongs to the channel being converted: an offset and a gain. The first stage removes the global zero and applies the global gain. The second stage applies the channel offset, then the channel gain.

Both stages use power-of-two normalisation. Each division truncates toward zero. The block supports unipolar and bipolar ranges. It can clamp the result to the code limits, and it can present the result as a 16-bit word.

A host latches one job with a one-cycle `start`. The block works through the two multiplications serially, one coefficient bit per cycle, and announces the result with a one-cycle `done`. The full job must fit inside a 163-cycle scaling window. The result and the two flags stay on the outputs until the next job completes.

Top module: `calibScaler`

## Requirements
- R1: After reset, `dataOut`, `signFlag`, `ovrFlag`, `done` and `busy` are all 0.
- R2: In unipolar mode (`bipolar`=0) the full result is t = trunc(trunc((raw − globalZero) × globalGain / 2^21) − off) × chanGain / 2^21). Every division truncates toward zero. Here `off` is the signed channel offset defined in R4.
- R3: In bipolar mode (`bipolar`=1) the full result is t = trunc((trunc((raw − globalZero) × globalGain / 2^22) + 2^23 − off) × chanGain / 2^21).
- R4: The channel offset code is decoded as follows. Bits 21:0 hold a magnitude. Bit 23 set makes `off` = +magnitude, and bit 23 clear makes `off` = −magnitude. Bit 22 has no effect. At the reset-state coefficient values (800000h, 800000h, 800000h, 200000h), `off` is 0.
- R5: With `clampEn`=1, a result t < 0 gives the 24-bit value 000000h and t > FFFFFFh gives FFFFFFh. Any other t gives t itself.
- R6: With `clampEn`=0, the 24-bit value is the low 24 bits of t. In both clamp settings, `signFlag` is 1 exactly when t < 0 and `ovrFlag` is 1 exactly when t > FFFFFFh.
- R7: With `narrow`=1, `dataOut` is {8'h00, bits 23:8 of the 24-bit value}. With `narrow`=0, `dataOut` is the 24-bit value.
- R8: `done` is a one-cycle pulse. `busy` is 1 from the cycle after an accepted `start` until the job finishes. `dataOut` and the flags hold their values until the next `done`.
- R9: A `start` that arrives while `busy`=1 is ignored. The job in flight completes with its own operands, and no second result follows.
- R10: `done` rises at most 163 cycles after the edge that accepted `start`.
- R11: A `start` presented in the same cycle as `done` is accepted. The finished result stays readable in that cycle, and the new job completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch the operands and begin a job |
| rawCode | input | 24 | Raw converter code |
| globalZero | input | 24 | Global zero-offset coefficient |
| globalGain | input | 24 | Global gain coefficient |
| chanZero | input | 24 | Channel offset, sign (bit 23) and magnitude (bits 21:0) |
| chanGain | input | 24 | Channel gain coefficient |
| bipolar | input | 1 | 1 selects the bipolar range formula |
| clampEn | input | 1 | 1 saturates the result to the code limits |
| narrow | input | 1 | 1 selects the 16-bit output word |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: a result is on the outputs |
| dataOut | output | 24 | Scaled code |
| signFlag | output | 1 | Unclamped result was negative |
| ovrFlag | output | 1 | Unclamped result exceeded FFFFFFh |

## Verification
Two events can land in the same cycle: the completion of one job and the acceptance of the next. The bench provokes this by raising `start` with fresh operands in the very cycle it sees `done`. In that cycle it checks that the finished result is still on the outputs. It then checks the second result against its own arithmetic model. A second overlap is a `start` pulse injected in the middle of a job: the bench confirms that the pulse neither changes the result nor produces an extra `done`.

// File: rtl/calibPkg.sv
package calibPkg;

  // Strobes issued by the sequencer to the arithmetic datapath
  typedef struct packed {
    logic load;   // capture operands, set up the first product
    logic step;   // one shift-add iteration
    logic mid;    // normalise stage one, set up the second product
    logic fin;    // normalise stage two, register the outputs
  } calStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL1,
    ST_MID,
    ST_MUL2,
    ST_FIN
  } calStateT;

endpackage

// File: rtl/calibCtrl.sv
module calibCtrl
  import calibPkg::*;
#(
  parameter int COEF_W = 24,
  parameter int BUDGET = 163
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output calStrobeT strb,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = $clog2(COEF_W);
  localparam int LAT_W = $clog2(BUDGET) + 2;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(COEF_W - 1);

  calStateT         stateQ, stateD;
  logic [CNT_W-1:0] cntQ;
  logic             doneQ;
  logic             lastStep;

  assign lastStep = (cntQ == LAST_STEP);

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        strb.load = 1'b1;
        stateD    = ST_MUL1;
      end
      ST_MUL1: begin
        strb.step = 1'b1;
        if (lastStep) stateD = ST_MID;
      end
      ST_MID: begin
        strb.mid = 1'b1;
        stateD   = ST_MUL2;
      end
      ST_MUL2: begin
        strb.step = 1'b1;
        if (lastStep) stateD = ST_FIN;
      end
      ST_FIN: begin
        strb.fin = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (stateQ == ST_FIN);
      if (strb.step) cntQ <= lastStep ? '0 : cntQ + 1'b1;
      else           cntQ <= '0;
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  // Latency watch for the budget check (cycles since the accepted start)
  logic [LAT_W-1:0] latQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          latQ <= '0;
    else if (strb.load) latQ <= LAT_W'(1);
    else if (busy)      latQ <= latQ + 1'b1;
  end

  p_budget_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (latQ < LAT_W'(BUDGET)))
    else $error("job exceeded the scaling budget");

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done)
    else $error("done held longer than one cycle");

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy)
    else $error("done while still busy");

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stateQ != ST_FIN && start) |=> busy)
    else $error("start during a job ended it early");

endmodule

// File: rtl/calibDatapath.sv
module calibDatapath
  import calibPkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int NORM_SH  = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobeT         strb,
  input  logic [DATA_W-1:0] rawCode,
  input  logic [DATA_W-1:0] globalZero,
  input  logic [DATA_W-1:0] globalGain,
  input  logic [DATA_W-1:0] chanZero,
  input  logic [DATA_W-1:0] chanGain,
  input  logic              bipolar,
  input  logic              clampEn,
  input  logic              narrow,
  output logic [DATA_W-1:0] dataOut,
  output logic              signFlag,
  output logic              ovrFlag
);

  localparam int ACC_W = 2 * DATA_W + 8;
  localparam int MAG_W = DATA_W - 2;
  localparam int PAD_W = DATA_W - NARROW_W;
  localparam logic signed [ACC_W-1:0] BIAS_N = ACC_W'((64'd1 << NORM_SH) - 64'd1);
  localparam logic signed [ACC_W-1:0] BIAS_W = ACC_W'((64'd1 << (NORM_SH + 1)) - 64'd1);
  localparam logic signed [ACC_W-1:0] MID_OFF = ACC_W'(64'd1 << (DATA_W - 1));

  logic signed [ACC_W-1:0] mcandQ, accQ;
  logic [DATA_W-1:0]       mplierQ;
  logic [DATA_W-1:0]       chGainQ, chZeroQ;
  logic                    bipQ, clampQ, narrowQ;

  // Division by a power of two, rounding toward zero
  function automatic logic signed [ACC_W-1:0] truncShift(
    input logic signed [ACC_W-1:0] v,
    input logic                    wide
  );
    logic signed [ACC_W-1:0] t;
    t = v;
    if (t[ACC_W-1]) t = t + (wide ? BIAS_W : BIAS_N);
    return wide ? (t >>> (NORM_SH + 1)) : (t >>> NORM_SH);
  endfunction

  // Stage one operand: raw minus global zero, sign extended
  logic signed [DATA_W:0]  diff;
  logic signed [ACC_W-1:0] diffExt;
  assign diff    = $signed({1'b0, rawCode}) - $signed({1'b0, globalZero});
  assign diffExt = {{(ACC_W - DATA_W - 1){diff[DATA_W]}}, diff};

  // Channel offset decode: sign in the top bit, magnitude in the low bits
  logic signed [ACC_W-1:0] magExt, chOff;
  assign magExt = {{(ACC_W - MAG_W){1'b0}}, chZeroQ[MAG_W-1:0]};
  assign chOff  = chZeroQ[DATA_W-1] ? magExt : -magExt;

  // Stage two operand
  logic signed [ACC_W-1:0] q1, s2;
  assign q1 = truncShift(accQ, bipQ);
  assign s2 = q1 + (bipQ ? MID_OFF : '0) - chOff;

  // Final normalisation and range handling
  logic signed [ACC_W-1:0] fullRes;
  logic                    isNeg, isOver;
  logic [DATA_W-1:0]       wideVal, outVal;
  assign fullRes = truncShift(accQ, 1'b0);
  assign isNeg   = fullRes[ACC_W-1];
  assign isOver  = !isNeg && (|fullRes[ACC_W-2:DATA_W]);

  always_comb begin
    wideVal = fullRes[DATA_W-1:0];
    if (clampQ) begin
      if (isNeg)       wideVal = '0;
      else if (isOver) wideVal = '1;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign outVal = narrowQ ? {{PAD_W{1'b0}}, wideVal[DATA_W-1 -: NARROW_W]} : wideVal;
    end else begin : g_nopad
      assign outVal = wideVal;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandQ   <= '0;
      accQ     <= '0;
      mplierQ  <= '0;
      chGainQ  <= '0;
      chZeroQ  <= '0;
      bipQ     <= 1'b0;
      clampQ   <= 1'b0;
      narrowQ  <= 1'b0;
      dataOut  <= '0;
      signFlag <= 1'b0;
      ovrFlag  <= 1'b0;
    end else begin
      if (strb.load) begin
        mcandQ  <= diffExt;
        mplierQ <= globalGain;
        accQ    <= '0;
        chGainQ <= chanGain;
        chZeroQ <= chanZero;
        bipQ    <= bipolar;
        clampQ  <= clampEn;
        narrowQ <= narrow;
      end
      if (strb.step) begin
        if (mplierQ[0]) accQ <= accQ + mcandQ;
        mcandQ  <= mcandQ <<< 1;
        mplierQ <= mplierQ >> 1;
      end
      if (strb.mid) begin
        mcandQ  <= s2;
        mplierQ <= chGainQ;
        accQ    <= '0;
      end
      if (strb.fin) begin
        dataOut  <= outVal;
        signFlag <= isNeg;
        ovrFlag  <= isOver;
      end
    end
  end

  p_drained_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mid || strb.fin) |-> (mplierQ == '0))
    else $error("product finished with multiplier bits left");

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(signFlag && ovrFlag))
    else $error("sign and overrange both set");

  p_clamp_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fin && clampQ && !narrowQ && isOver) |=> (dataOut == '1))
    else $error("overrange not saturated");

  p_clamp_lo_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fin && clampQ && isNeg) |=> (dataOut == '0))
    else $error("negative not saturated");

  p_narrow_pad_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fin && narrowQ) |=> (dataOut[DATA_W-1 -: PAD_W] == '0))
    else $error("narrow word has upper bits set");

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fin |=> $stable(dataOut))
    else $error("result changed outside completion");

endmodule

// File: rtl/calibScaler.sv
module calibScaler
  import calibPkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int NORM_SH  = 21,
  parameter int BUDGET   = 163
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] rawCode,
  input  logic [DATA_W-1:0] globalZero,
  input  logic [DATA_W-1:0] globalGain,
  input  logic [DATA_W-1:0] chanZero,
  input  logic [DATA_W-1:0] chanGain,
  input  logic              bipolar,
  input  logic              clampEn,
  input  logic              narrow,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] dataOut,
  output logic              signFlag,
  output logic              ovrFlag
);

  calStrobeT strb;

  calibCtrl #(
    .COEF_W (DATA_W),
    .BUDGET (BUDGET)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  calibDatapath #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .NORM_SH  (NORM_SH)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rawCode    (rawCode),
    .globalZero (globalZero),
    .globalGain (globalGain),
    .chanZero   (chanZero),
    .chanGain   (chanGain),
    .bipolar    (bipolar),
    .clampEn    (clampEn),
    .narrow     (narrow),
    .dataOut    (dataOut),
    .signFlag   (signFlag),
    .ovrFlag    (ovrFlag)
  );

endmodule

// File: tb/tb_calibScaler.sv
`timescale 1ns/1ps
module tb_calibScaler;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] rawCode = '0, globalZero = '0, globalGain = '0, chanZero = '0, chanGain = '0;
  logic        bipolar = 1'b0, clampEn = 1'b0, narrow = 1'b0;
  logic        busy, done, signFlag, ovrFlag;
  logic [23:0] dataOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  calibScaler dut (
    .clk(clk), .rstN(rstN), .start(start), .rawCode(rawCode),
    .globalZero(globalZero), .globalGain(globalGain), .chanZero(chanZero),
    .chanGain(chanGain), .bipolar(bipolar), .clampEn(clampEn), .narrow(narrow),
    .busy(busy), .done(done), .dataOut(dataOut), .signFlag(signFlag), .ovrFlag(ovrFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Arithmetic model built from the requirements
  task automatic model(input logic [23:0] raw, gz, gf, cz, cf,
                       input logic bip, cl, nar,
                       output logic [23:0] d, output logic s, output logic o);
    longint dd, p1, q1, off, s2, r, den1;
    logic [23:0] v;
    dd   = longint'(raw) - longint'(gz);
    p1   = dd * longint'(gf);
    den1 = bip ? 64'sd4194304 : 64'sd2097152;
    q1   = p1 / den1;
    off  = longint'(cz[21:0]);
    if (!cz[23]) off = -off;
    s2   = q1 + (bip ? 64'sd8388608 : 64'sd0) - off;
    r    = (s2 * longint'(cf)) / 64'sd2097152;
    s    = (r < 0);
    o    = (r > 64'sd16777215);
    v    = r[23:0];
    if (cl) begin
      if (s)      v = 24'h000000;
      else if (o) v = 24'hFFFFFF;
    end
    d = nar ? {8'h00, v[23:8]} : v;
  endtask

  task automatic setOps(input logic [23:0] raw, gz, gf, cz, cf, input logic bip, cl, nar);
    rawCode = raw; globalZero = gz; globalGain = gf; chanZero = cz; chanGain = cf;
    bipolar = bip; clampEn = cl; narrow = nar;
  endtask

  // Waits (sampling on falling edges) until done; returns cycles counted
  task automatic waitDone(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 400);
  endtask

  task automatic runCase(input logic [23:0] raw, gz, gf, cz, cf, input logic bip, cl, nar);
    logic [23:0] ed; logic es, eo; int lat;
    string mtag, ctag, ntag;
    model(raw, gz, gf, cz, cf, bip, cl, nar, ed, es, eo);
    mtag = bip ? "R3" : "R2";
    ctag = cl ? "R5" : "R6";
    ntag = nar ? "R7" : "R7 wide";
    @(negedge clk);
    setOps(raw, gz, gf, cz, cf, bip, cl, nar);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", 32'(busy), 32'd1);
    waitDone(lat);
    lat++;
    chk("R10 latency within budget", 32'(lat <= 163), 32'd1);
    chk({mtag, " ", ctag, " ", ntag, " data"}, 32'(dataOut), 32'(ed));
    chk({ctag, " sign flag"}, 32'(signFlag), 32'(es));
    chk({ctag, " overrange flag"}, 32'(ovrFlag), 32'(eo));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  logic [23:0] raws [12] = '{24'h000000, 24'h000001, 24'h3FFFFF, 24'h400000,
                              24'h7FFFFF, 24'h800000, 24'h800001, 24'hBFFFFF,
                              24'hC00000, 24'hFFFFFF, 24'h123456, 24'hABCDEF};
  logic [23:0] cGz [5] = '{24'h800000, 24'h7F0000, 24'h800000, 24'h810000, 24'h000000};
  logic [23:0] cGf [5] = '{24'h800000, 24'h812345, 24'h800000, 24'h400000, 24'hFFFFFF};
  logic [23:0] cCz [5] = '{24'h800000, 24'h80ABCD, 24'h000100, 24'hC12345, 24'h3FFFFF};
  logic [23:0] cCf [5] = '{24'h200000, 24'h1F8000, 24'h200000, 24'h3FFFFF, 24'h100001};

  initial begin
    logic [23:0] ed, ed2, keep; logic es, eo, es2, eo2; int lat;

    // R1 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 dataOut", 32'(dataOut), 32'd0);
    chk("R1 signFlag", 32'(signFlag), 32'd0);
    chk("R1 ovrFlag", 32'(ovrFlag), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);

    // Sweep over codes, coefficient sets and the three mode bits
    for (int c = 0; c < 5; c++)
      for (int m = 0; m < 8; m++)
        for (int i = 0; i < 12; i++)
          runCase(raws[i], cGz[c], cGf[c], cCz[c], cCf[c], m[0], m[1], m[2]);

    // R4: bit 22 of the channel offset has no effect
    runCase(24'h9ABCDE, 24'h800000, 24'h800000, 24'h800010, 24'h200000, 1'b0, 1'b0, 1'b0);
    keep = dataOut;
    runCase(24'h9ABCDE, 24'h800000, 24'h800000, 24'hC00010, 24'h200000, 1'b0, 1'b0, 1'b0);
    chk("R4 bit22 ignored", 32'(dataOut), 32'(keep));
    runCase(24'h9ABCDE, 24'h800000, 24'h800000, 24'h400010, 24'h200000, 1'b0, 1'b0, 1'b0);
    chk("R4 negative sign changes result", 32'(dataOut != keep), 32'd1);

    // R8: result holds after done
    keep = dataOut;
    repeat (7) @(negedge clk);
    chk("R8 result held", 32'(dataOut), 32'(keep));
    chk("R8 done single pulse", 32'(done), 32'd0);

    // R9: start during a job is ignored
    model(24'h654321, 24'h7F0000, 24'h812345, 24'h80ABCD, 24'h1F8000, 1'b1, 1'b0, 1'b0, ed, es, eo);
    @(negedge clk);
    setOps(24'h654321, 24'h7F0000, 24'h812345, 24'h80ABCD, 24'h1F8000, 1'b1, 1'b0, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    setOps(24'h111111, 24'h000000, 24'hFFFFFF, 24'h3FFFFF, 24'h100001, 1'b0, 1'b1, 1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    chk("R9 result from first operands", 32'(dataOut), 32'(ed));
    repeat (70) @(negedge clk);
    chk("R9 no second result busy", 32'(busy), 32'd0);
    chk("R9 no second result data", 32'(dataOut), 32'(ed));

    // R11: new start in the done cycle
    model(24'hFEDCBA, 24'h810000, 24'h400000, 24'hC12345, 24'h3FFFFF, 1'b0, 1'b0, 1'b0, ed, es, eo);
    model(24'h0F0F0F, 24'h800000, 24'h800000, 24'h000100, 24'h200000, 1'b1, 1'b1, 1'b0, ed2, es2, eo2);
    @(negedge clk);
    setOps(24'hFEDCBA, 24'h810000, 24'h400000, 24'hC12345, 24'h3FFFFF, 1'b0, 1'b0, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    setOps(24'h0F0F0F, 24'h800000, 24'h800000, 24'h000100, 24'h200000, 1'b1, 1'b1, 1'b0);
    start = 1'b1;
    chk("R11 first result in done cycle", 32'(dataOut), 32'(ed));
    chk("R11 first sign in done cycle", 32'(signFlag), 32'(es));
    @(negedge clk);
    start = 1'b0;
    chk("R11 second job accepted", 32'(busy), 32'd1);
    waitDone(lat);
    chk("R11 second result", 32'(dataOut), 32'(ed2));
    chk("R11 second sign", 32'(signFlag), 32'(es2));
    chk("R11 second overrange", 32'(ovrFlag), 32'(eo2));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule